// File: doc/BRIEF.md
# Palette Table Loader

The block copies a run of 16-bit colour palette entries from system memory into texture memory. A single start pulse supplies the horizontal extent of the run as two 10.2 fixed-point coordinates, a row coordinate, a source base address and a row pitch in bytes, plus the texture memory word at which the palette begins. The block computes how many entries to move and where the first one sits in system memory. It then streams them out, one per clock, each to its own 64-bit texture memory word.

Every entry is handled as a raw 16-bit value, whatever colour encoding it holds. A per-load flag decides whether the entry fills only the lowest 16-bit lane of its destination word or is copied into all four lanes. Before any traffic starts, a load that would run past the end of texture memory is rejected. A rejected load reports an error and touches neither memory.

System memory is read through a simple port with a fixed one-cycle read latency. Texture memory is written through a word-addressed port with one enable per 16-bit lane.

Top module: `pal_loader`

## Requirements
- R1: The number of entries written is ((coord_right - coord_left) mod 4096) >> 2, plus one. The subtraction uses the full 12-bit 10.2 values, so fractional bits take part in it.
- R2: Entry i is read from byte address src_base + (coord_top>>2)*src_pitch + (coord_left>>2)*2 + 2*i, modulo 2^24. Each read returns one 16-bit entry on mem_rd_data in the cycle after mem_rd_en.
- R3: Entry i is written to texture memory word tile_tmem + i, which is halfword index 4*tile_tmem + 4*i. Lane 0 is tm_data[15:0] and is enabled by tm_hw_en[0].
- R4: With replicate low, tm_hw_en is 4'b0001 and tm_data[63:16] is zero. With replicate high, tm_hw_en is 4'b1111 and all four lanes carry the entry. tm_hw_en is zero when tm_we is low.
- R5: With start sampled at clock edge 0, read i is issued in the cycle after edge i and write i happens one cycle after read i. Reads and writes each run back to back.
- R6: After the final write of a valid load, done is high for exactly one cycle, with error low.
- R7: A load with tile_tmem + count > 512 is invalid. In the cycle after start, done and error are both high for one cycle, and no read or write is issued.
- R8: A start pulse that arrives while a load is in progress is ignored and does not change the running load.
- R9: While reset is held and just after it, mem_rd_en, tm_we, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; sampled only while idle |
| coord_left | input | 12 | Left coordinate, 10.2 fixed point |
| coord_right | input | 12 | Right coordinate, 10.2 fixed point |
| coord_top | input | 12 | Row coordinate, 10.2 fixed point |
| src_base | input | 24 | Source image base byte address |
| src_pitch | input | 12 | Source row pitch in bytes |
| tile_tmem | input | 9 | First destination texture memory word |
| replicate | input | 1 | Copy each entry into all four lanes |
| mem_rd_en | output | 1 | System memory read strobe |
| mem_rd_addr | output | 24 | System memory byte address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| tm_we | output | 1 | Texture memory write strobe |
| tm_addr | output | 9 | Texture memory word address |
| tm_data | output | 64 | Texture memory write data |
| tm_hw_en | output | 4 | Per-lane write enables |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with done when the load was rejected |

## Verification
A wrong remaining-entry counter shows up at the ports within one cycle of the expected end. The read strobe stops early or runs on, and done lands on the wrong cycle. A wrong address register is visible on the first read or the first write, because each expected address is compared cycle by cycle from start. A bad range check appears in the cycle right after start, as traffic where error was due or as an error on a load that fits exactly. A lane-mode slip shows as wrong enables or stale upper lanes on the first write.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int ENTRY_W = 16;
    localparam int LANES   = 4;
    localparam int WORD_W  = ENTRY_W * LANES;

    typedef enum logic {
        LOAD_IDLE = 1'b0,
        LOAD_RUN  = 1'b1
    } load_state_e;

    typedef enum logic {
        LANE_ONE = 1'b0,
        LANE_ALL = 1'b1
    } lane_mode_e;

    // Place an entry in lane 0 only, or in every lane.
    function automatic logic [WORD_W-1:0] spread_entry(
        input logic [ENTRY_W-1:0] e,
        input lane_mode_e         m
    );
        logic [WORD_W-1:0] w;
        for (int l = 0; l < LANES; l++) begin
            w[l*ENTRY_W +: ENTRY_W] = (m == LANE_ALL || l == 0) ? e : '0;
        end
        return w;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input lane_mode_e m);
        logic [LANES-1:0] k;
        for (int l = 0; l < LANES; l++) begin
            k[l] = (m == LANE_ALL) || (l == 0);
        end
        return k;
    endfunction

endpackage

// File: rtl/pal_setup.sv
module pal_setup #(
    parameter int COORD_W    = 12,
    parameter int FRAC_W     = 2,
    parameter int ADDR_W     = 24,
    parameter int PITCH_W    = 12,
    parameter int TMEM_AW    = 9,
    parameter int TMEM_WORDS = 512,
    parameter int CNT_W      = COORD_W - FRAC_W + 1
) (
    input  logic [COORD_W-1:0] left_i,
    input  logic [COORD_W-1:0] right_i,
    input  logic [COORD_W-1:0] top_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [PITCH_W-1:0] pitch_i,
    input  logic [TMEM_AW-1:0] tile_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [ADDR_W-1:0]  src_o,
    output logic               bad_o
);
    localparam int INT_W  = COORD_W - FRAC_W;
    localparam int CMP_W  = ((CNT_W > TMEM_AW) ? CNT_W : TMEM_AW) + 1;
    localparam int PROD_W = INT_W + PITCH_W;

    logic [COORD_W-1:0] span;
    logic [INT_W-1:0]   row_int;
    logic [INT_W-1:0]   col_int;
    logic [PROD_W-1:0]  row_off;
    logic [ADDR_W-1:0]  col_off;
    logic               unused_frac;

    assign span        = right_i - left_i;
    assign count_o     = CNT_W'(span >> FRAC_W) + CNT_W'(1);
    assign row_int     = top_i[COORD_W-1:FRAC_W];
    assign col_int     = left_i[COORD_W-1:FRAC_W];
    assign row_off     = PROD_W'(row_int) * PROD_W'(pitch_i);
    assign col_off     = ADDR_W'({col_int, 1'b0});
    assign src_o       = base_i + ADDR_W'(row_off) + col_off;
    assign bad_o       = (CMP_W'(tile_i) + CMP_W'(count_o)) > CMP_W'(TMEM_WORDS);
    assign unused_frac = ^top_i[FRAC_W-1:0];

endmodule

// File: rtl/pal_sequencer.sv
module pal_sequencer
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int TMEM_AW = 9,
    parameter int CNT_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [ADDR_W-1:0]  src_i,
    input  logic [TMEM_AW-1:0] tile_i,
    input  logic               rep_i,
    input  logic               bad_i,
    output logic               rd_en_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic               beat_o,
    output logic [TMEM_AW-1:0] wr_addr_o,
    output lane_mode_e         mode_o,
    output logic               done_o,
    output logic               error_o
);
    localparam logic [ADDR_W-1:0] SRC_STEP = ADDR_W'(ENTRY_W / 8);

    load_state_e        state_q;
    logic [CNT_W-1:0]   rd_left_q;
    logic [ADDR_W-1:0]  rd_addr_q;
    logic [TMEM_AW-1:0] wr_addr_q;
    lane_mode_e         mode_q;
    logic               beat_q;
    logic               last_q;
    logic               done_q;
    logic               err_q;
    logic               rd_fire;

    assign rd_fire = (state_q == LOAD_RUN) && (rd_left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LOAD_IDLE;
            rd_left_q <= '0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            mode_q    <= LANE_ONE;
            beat_q    <= 1'b0;
            last_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            beat_q <= rd_fire;
            last_q <= rd_fire && (rd_left_q == CNT_W'(1));
            case (state_q)
                LOAD_IDLE: begin
                    if (start_i) begin
                        if (bad_i) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            state_q   <= LOAD_RUN;
                            rd_left_q <= count_i;
                            rd_addr_q <= src_i;
                            wr_addr_q <= tile_i;
                            mode_q    <= rep_i ? LANE_ALL : LANE_ONE;
                        end
                    end
                end
                LOAD_RUN: begin
                    if (rd_fire) begin
                        rd_left_q <= rd_left_q - CNT_W'(1);
                        rd_addr_q <= rd_addr_q + SRC_STEP;
                    end
                    if (beat_q) begin
                        wr_addr_q <= wr_addr_q + TMEM_AW'(1);
                        if (last_q) begin
                            done_q  <= 1'b1;
                            state_q <= LOAD_IDLE;
                        end
                    end
                end
                default: state_q <= LOAD_IDLE;
            endcase
        end
    end

    assign rd_en_o   = rd_fire;
    assign rd_addr_o = rd_addr_q;
    assign beat_o    = beat_q;
    assign wr_addr_o = wr_addr_q;
    assign mode_o    = mode_q;
    assign done_o    = done_q;
    assign error_o   = err_q;

    AST_RD_STRIDE: assert property (@(posedge clk) disable iff (rst)
        rd_fire && $past(rd_fire) |-> rd_addr_q == $past(rd_addr_q) + SRC_STEP); // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
        beat_q && $past(beat_q) |-> wr_addr_q == $past(wr_addr_q) + TMEM_AW'(1)); // R3
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_q && !err_q |-> $past(beat_q)); // R6
    AST_ERR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !$past(beat_q) && !$past(rd_fire) && !rd_fire); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> done_q); // R7
    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $past(state_q == LOAD_RUN) && state_q == LOAD_RUN |-> $stable(mode_q)); // R8

endmodule

// File: rtl/pal_lane_pack.sv
module pal_lane_pack
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               beat_i,
    input  lane_mode_e         mode_i,
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               we_o,
    output logic [WORD_W-1:0]  data_o,
    output logic [LANES-1:0]   hw_en_o
);
    assign we_o    = beat_i;
    assign data_o  = beat_i ? spread_entry(entry_i, mode_i) : '0;
    assign hw_en_o = beat_i ? lane_mask(mode_i) : '0;

    AST_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
        we_o |-> (hw_en_o == 4'h1 || hw_en_o == 4'hF)); // R4
    AST_IDLE_MASK: assert property (@(posedge clk) disable iff (rst)
        !we_o |-> hw_en_o == '0); // R4

endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int COORD_W    = 12,
    parameter int FRAC_W     = 2,
    parameter int ADDR_W     = 24,
    parameter int PITCH_W    = 12,
    parameter int TMEM_AW    = 9,
    parameter int TMEM_WORDS = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [COORD_W-1:0]   coord_left,
    input  logic [COORD_W-1:0]   coord_right,
    input  logic [COORD_W-1:0]   coord_top,
    input  logic [ADDR_W-1:0]    src_base,
    input  logic [PITCH_W-1:0]   src_pitch,
    input  logic [TMEM_AW-1:0]   tile_tmem,
    input  logic                 replicate,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic [ENTRY_W-1:0]   mem_rd_data,
    output logic                 tm_we,
    output logic [TMEM_AW-1:0]   tm_addr,
    output logic [WORD_W-1:0]    tm_data,
    output logic [LANES-1:0]     tm_hw_en,
    output logic                 done,
    output logic                 error
);
    localparam int CNT_W = COORD_W - FRAC_W + 1;

    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] src_w;
    logic              bad_w;
    logic              beat_w;
    lane_mode_e        mode_w;

    pal_setup #(
        .COORD_W(COORD_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W),
        .PITCH_W(PITCH_W), .TMEM_AW(TMEM_AW), .TMEM_WORDS(TMEM_WORDS),
        .CNT_W(CNT_W)
    ) u_setup (
        .left_i (coord_left),
        .right_i(coord_right),
        .top_i  (coord_top),
        .base_i (src_base),
        .pitch_i(src_pitch),
        .tile_i (tile_tmem),
        .count_o(cnt_w),
        .src_o  (src_w),
        .bad_o  (bad_w)
    );

    pal_sequencer #(
        .ADDR_W(ADDR_W), .TMEM_AW(TMEM_AW), .CNT_W(CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .count_i  (cnt_w),
        .src_i    (src_w),
        .tile_i   (tile_tmem),
        .rep_i    (replicate),
        .bad_i    (bad_w),
        .rd_en_o  (mem_rd_en),
        .rd_addr_o(mem_rd_addr),
        .beat_o   (beat_w),
        .wr_addr_o(tm_addr),
        .mode_o   (mode_w),
        .done_o   (done),
        .error_o  (error)
    );

    pal_lane_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .beat_i (beat_w),
        .mode_i (mode_w),
        .entry_i(mem_rd_data),
        .we_o   (tm_we),
        .data_o (tm_data),
        .hw_en_o(tm_hw_en)
    );

endmodule

// File: tb/pal_loader_bench.sv
`timescale 1ns/1ps
module pal_loader_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] coord_left = '0, coord_right = '0, coord_top = '0;
    logic [23:0] src_base = '0;
    logic [11:0] src_pitch = '0;
    logic [8:0]  tile_tmem = '0;
    logic        replicate = 1'b0;
    logic        mem_rd_en;
    logic [23:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        tm_we;
    logic [8:0]  tm_addr;
    logic [63:0] tm_data;
    logic [3:0]  tm_hw_en;
    logic        done, error;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pal_loader u_pal_loader (
        .clk(clk), .rst(rst), .start(start),
        .coord_left(coord_left), .coord_right(coord_right), .coord_top(coord_top),
        .src_base(src_base), .src_pitch(src_pitch), .tile_tmem(tile_tmem),
        .replicate(replicate),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .tm_we(tm_we), .tm_addr(tm_addr), .tm_data(tm_data), .tm_hw_en(tm_hw_en),
        .done(done), .error(error)
    );

    function automatic logic [15:0] mem_fn(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'hA5C3;
    endfunction

    always_ff @(posedge clk) mem_rd_data <= mem_fn(mem_rd_addr);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic run_load(input logic [11:0] l, input logic [11:0] r, input logic [11:0] t,
                            input logic [23:0] b, input logic [11:0] p, input logic [8:0] tile,
                            input bit rep, input bit poke);
        logic [11:0] span;
        int cnt, lim;
        bit bad;
        logic [23:0] src;
        span = r - l;
        cnt  = int'(span >> 2) + 1;
        bad  = (int'(tile) + cnt) > 512;
        src  = b + 24'(t[11:2]) * 24'(p) + 24'({l[11:2], 1'b0});
        lim  = bad ? 4 : cnt + 3;
        @(negedge clk);
        coord_left = l; coord_right = r; coord_top = t;
        src_base = b; src_pitch = p; tile_tmem = tile; replicate = rep;
        start = 1'b1;
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            if (bad) begin
                check(mem_rd_en == 1'b0 && tm_we == 1'b0, "R7 no traffic", {mem_rd_en, tm_we}, 0);
                check(done == (c == 1) && error == (c == 1), "R7 done+error", {done, error},
                      (c == 1) ? 2'b11 : 2'b00);
            end else begin
                bit exp_rd = (c <= cnt);
                bit exp_we = (c >= 2) && (c <= cnt + 1);
                check(mem_rd_en == exp_rd, "R1 R5 read strobe", mem_rd_en, exp_rd);
                if (exp_rd && mem_rd_en)
                    check(mem_rd_addr == src + 24'(2 * (c - 1)), "R2 read address",
                          mem_rd_addr, src + 24'(2 * (c - 1)));
                check(tm_we == exp_we, "R1 R5 write strobe", tm_we, exp_we);
                if (exp_we && tm_we) begin
                    logic [23:0] sa;
                    logic [15:0] e;
                    logic [63:0] w;
                    sa = src + 24'(2 * (c - 2));
                    e  = mem_fn(sa);
                    w  = rep ? {4{e}} : {48'h0, e};
                    check(tm_addr == tile + 9'(c - 2), "R3 write word", tm_addr, tile + 9'(c - 2));
                    check(tm_data == w, "R2 R4 write data", tm_data, w);
                    check(tm_hw_en == (rep ? 4'hF : 4'h1), "R4 lane enables", tm_hw_en,
                          rep ? 4'hF : 4'h1);
                end else begin
                    check(tm_hw_en == 4'h0, "R4 idle enables", tm_hw_en, 0);
                end
                check(done == (c == cnt + 2) && error == 1'b0, "R6 done pulse", {done, error},
                      {(c == cnt + 2), 1'b0});
            end
            // R8: a second start during the load with other parameters
            if (c == 1 || (poke && c == 3)) start = 1'b0;
            if (poke && c == 2) begin
                start = 1'b1;
                tile_tmem = tile + 9'd7;
                src_base = b + 24'h100;
                replicate = ~rep;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(mem_rd_en == 0 && tm_we == 0 && done == 0 && error == 0, "R9 reset outputs",
              {mem_rd_en, tm_we, done, error}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_rd_en == 0 && tm_we == 0 && done == 0 && error == 0, "R9 after reset",
              {mem_rd_en, tm_we, done, error}, 0);
        // R1 single entry, fractional span below one entry
        run_load(12'd5, 12'd6, 12'd8, 24'h001000, 12'd64, 9'd0, 1'b0, 1'b0);
        // R1 fractional bits take part: 3 -> 7 gives two entries
        run_load(12'd3, 12'd7, 12'd0, 24'h002000, 12'd32, 9'd10, 1'b1, 1'b0);
        // R7 exact fit is valid, one past is rejected
        run_load(12'd0, 12'd44, 12'd4, 24'h003000, 12'd16, 9'd500, 1'b0, 1'b0);
        run_load(12'd0, 12'd44, 12'd4, 24'h003000, 12'd16, 9'd501, 1'b1, 1'b0);
        // R7 right below left wraps to a huge count
        run_load(12'd40, 12'd8, 12'd0, 24'h0, 12'd0, 9'd0, 1'b0, 1'b0);
        // R8 start ignored mid-load
        run_load(12'd16, 12'd80, 12'd12, 24'h00FF00, 12'd320, 9'd100, 1'b0, 1'b1);
        // R2 address wrap at 2^24
        run_load(12'd0, 12'd12, 12'd0, 24'hFFFFFC, 12'd0, 9'd200, 1'b1, 1'b0);
        for (int k = 0; k < 60; k++) begin
            logic [11:0] l;
            logic [11:0] r;
            l = 12'($urandom_range(0, 3000));
            r = l + 12'($urandom_range(0, 160));
            run_load(l, r, 12'($urandom), 24'($urandom), 12'($urandom), 9'($urandom),
                     1'($urandom), (k % 7) == 3);
        end
        repeat (2) @(negedge clk);
        summary();
    end
endmodule